// File: doc/BRIEF.md
# Indirect Command Bus Bridge

This block lets a 64-bit register host reach a 32-bit internal peripheral bus through a window of four 8-byte registers. The host first places write data in a data register. It then writes one packed command word that holds a direction flag, a byte count and a 32-bit internal address. That single write launches one internal transaction on a valid/ready master port. The host write is not acknowledged until the internal response has come back.

The outcome is posted into a status register. That register carries a completion flag and, for reads, the returned data, with the byte at the lowest internal address placed most significant. Reading the status register hands back its contents and empties it in the same access. Commands whose byte count is larger than eight are refused: nothing goes out on the internal bus and the status register keeps its value. The reset register accepts writes and ignores them.

Top module: `ind_cmd_bridge`

## Requirements
- R1: The register index is `host_addr[4:3]`: 0 is command, 1 is reset, 2 is status and 3 is data. An access acts only when all eight `host_be` bits are set and `host_addr[2:0]` is zero. Any other access is still acknowledged, changes no state, and a read returns zero.
- R2: A command word is decoded as follows: bit 48 set means read, bits 59:56 hold the byte count, and bits 31:0 hold the internal address. These fields appear on `int_we` (inverted read flag), `int_size` and `int_addr`.
- R3: A command with a byte count above 8 issues no internal transaction, leaves the status register unchanged, and is acknowledged.
- R4: A read that completes without error sets status to bit 11 ORed with a 32-bit value shifted left by 26. That value is built from the response lanes, with `int_rdata[7:0]` (address offset 0) in bits 31:24, down to `int_rdata[31:24]` in bits 7:0. Lanes whose offset is at or above the byte count read as zero.
- R5: A read that completes with `int_err` set sets status to bit 11 ORed with 32'hFFFFFFFF shifted left by 26.
- R6: A write drives `int_wdata` with the data register in reversed byte order, so `int_wdata[7:0]` is data bits 31:24. It sets status to bit 11 alone, whether or not `int_err` is set.
- R7: A status read returns the stored value, and the register reads zero afterwards.
- R8: A data write stores `host_wdata[63:32]`. A data read returns the stored word in bits 63:32 and zeros in bits 31:0.
- R9: Command and reset reads return zero. Writes to reset and status change nothing.
- R10: `int_valid` and its fields stay stable until `int_ready` is seen. The response is taken from the next cycle on. `host_ack` lasts one cycle and, for a launched command, follows the response. The host holds its request until `host_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | Host write when high |
| host_addr | input | 5 | Host byte address within the window |
| host_be | input | 8 | Host byte enables |
| host_wdata | input | 64 | Host write data |
| host_ack | output | 1 | One-cycle access completion |
| host_rdata | output | 64 | Host read data, valid with host_ack |
| int_valid | output | 1 | Internal request valid |
| int_ready | input | 1 | Internal request accepted |
| int_we | output | 1 | Internal write when high |
| int_addr | output | 32 | Internal address |
| int_size | output | 4 | Internal byte count |
| int_wdata | output | 32 | Internal write data, lane k = offset k |
| int_rvalid | input | 1 | Internal response valid |
| int_rdata | input | 32 | Internal read data, lane k = offset k |
| int_err | input | 1 | Internal response error, valid with int_rvalid |

## Verification
The hardest case to reach is a refused command. To be observable it must meet a status register that already holds a result, so an unchanged value can be told apart from a cleared or overwritten one. The stimulus therefore launches a good read and skips the status read. It then writes an oversized command and only afterwards reads status, while a transaction counter in the bus model shows that nothing was issued. Short byte counts are driven on reads so that the lane masking of the unused bytes becomes visible.

// File: rtl/icb_pkg.sv
package icb_pkg;
    localparam int HOST_DW   = 64;
    localparam int INT_AW    = 32;
    localparam int INT_DW    = 32;
    localparam int LANES     = INT_DW / 8;
    localparam int SIZE_W    = 4;
    localparam int MAX_BYTES = 8;

    localparam int RD_BIT    = 48;
    localparam int SIZE_LSB  = 56;
    localparam int DONE_BIT  = 11;
    localparam int DATA_SH   = 26;

    typedef enum logic [1:0] {
        IDX_CMD  = 2'd0,
        IDX_RST  = 2'd1,
        IDX_STAT = 2'd2,
        IDX_DATA = 2'd3
    } reg_idx_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } seq_state_e;

    typedef struct packed {
        logic              rd;
        logic [SIZE_W-1:0] size;
        logic [INT_AW-1:0] addr;
    } cmd_t;

    function automatic logic [HOST_DW-1:0] done_word();
        logic [HOST_DW-1:0] w;
        w = '0;
        w[DONE_BIT] = 1'b1;
        return w;
    endfunction
endpackage

// File: rtl/icb_cmd_decode.sv
module icb_cmd_decode
    import icb_pkg::*;
(
    input  logic                rd_flag,
    input  logic [SIZE_W-1:0]   size_f,
    input  logic [INT_AW-1:0]   addr_f,
    output cmd_t                cmd,
    output logic                size_ok
);
    always_comb begin
        cmd.rd   = rd_flag;
        cmd.size = size_f;
        cmd.addr = addr_f;
        size_ok  = (32'(size_f) <= MAX_BYTES);
    end
endmodule

// File: rtl/icb_byte_order.sv
module icb_byte_order
    import icb_pkg::*;
#(
    parameter int NLANES  = 4,
    parameter bit MASK_EN = 1'b0
) (
    input  logic [8*NLANES-1:0] din,
    input  logic [SIZE_W-1:0]   size,
    output logic [8*NLANES-1:0] dout
);
    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        logic keep;
        if (MASK_EN) begin : g_mask
            assign keep = (32'(size) > k);
        end else begin : g_all
            assign keep = 1'b1;
        end
        assign dout[8*(NLANES-1-k) +: 8] = keep ? din[8*k +: 8] : 8'h00;
    end
endmodule

// File: rtl/icb_status_fmt.sv
module icb_status_fmt
    import icb_pkg::*;
(
    input  logic                rd,
    input  logic                err,
    input  logic [SIZE_W-1:0]   size,
    input  logic [INT_DW-1:0]   rdata,
    output logic [HOST_DW-1:0]  status
);
    logic [INT_DW-1:0] assembled;

    icb_byte_order #(.NLANES(LANES), .MASK_EN(1'b1)) u_rd_order (
        .din  (rdata),
        .size (size),
        .dout (assembled)
    );

    always_comb begin
        status = done_word();
        if (rd) begin
            if (err) status = status | (HOST_DW'({INT_DW{1'b1}}) << DATA_SH);
            else     status = status | (HOST_DW'(assembled) << DATA_SH);
        end
    end
endmodule

// File: rtl/icb_seq.sv
module icb_seq
    import icb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic imm,
    input  logic int_ready,
    input  logic int_rvalid,
    output logic idle,
    output logic int_valid,
    output logic done_evt,
    output logic host_ack
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ISSUE;
                      else if (imm) state_d = ST_RESP;
            ST_ISSUE: if (int_ready) state_d = ST_WAIT;
            ST_WAIT:  if (int_rvalid) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign idle      = (state_q == ST_IDLE);
    assign int_valid = (state_q == ST_ISSUE);
    assign done_evt  = (state_q == ST_WAIT) && int_rvalid;
    assign host_ack  = (state_q == ST_RESP);
endmodule

// File: rtl/ind_cmd_bridge.sv
module ind_cmd_bridge
    import icb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                host_req,
    input  logic                host_we,
    input  logic [4:0]          host_addr,
    input  logic [7:0]          host_be,
    input  logic [HOST_DW-1:0]  host_wdata,
    output logic                host_ack,
    output logic [HOST_DW-1:0]  host_rdata,
    output logic                int_valid,
    input  logic                int_ready,
    output logic                int_we,
    output logic [INT_AW-1:0]   int_addr,
    output logic [SIZE_W-1:0]   int_size,
    output logic [INT_DW-1:0]   int_wdata,
    input  logic                int_rvalid,
    input  logic [INT_DW-1:0]   int_rdata,
    input  logic                int_err
);
    logic               idle, accept, full, start, imm, done_evt, size_ok;
    reg_idx_e           idx;
    cmd_t               cmd_dec, cmd_q;
    logic [HOST_DW-1:0] status_q, status_new, rdata_q;
    logic [INT_DW-1:0]  data_q;

    assign idx    = reg_idx_e'(host_addr[4:3]);
    assign full   = (&host_be) && (host_addr[2:0] == 3'b000);
    assign accept = host_req && idle;
    assign start  = accept && full && host_we && (idx == IDX_CMD) && size_ok;
    assign imm    = accept && !start;

    icb_cmd_decode u_dec (
        .rd_flag (host_wdata[RD_BIT]),
        .size_f  (host_wdata[SIZE_LSB +: SIZE_W]),
        .addr_f  (host_wdata[INT_AW-1:0]),
        .cmd     (cmd_dec),
        .size_ok (size_ok)
    );

    icb_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .imm        (imm),
        .int_ready  (int_ready),
        .int_rvalid (int_rvalid),
        .idle       (idle),
        .int_valid  (int_valid),
        .done_evt   (done_evt),
        .host_ack   (host_ack)
    );

    icb_byte_order #(.NLANES(LANES), .MASK_EN(1'b0)) u_wr_order (
        .din  (data_q),
        .size (cmd_q.size),
        .dout (int_wdata)
    );

    icb_status_fmt u_fmt (
        .rd     (cmd_q.rd),
        .err    (int_err),
        .size   (cmd_q.size),
        .rdata  (int_rdata),
        .status (status_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            data_q   <= '0;
            rdata_q  <= '0;
            cmd_q    <= '0;
        end else begin
            if (accept) begin
                rdata_q <= '0;
                if (full) begin
                    if (host_we) begin
                        unique case (idx)
                            IDX_CMD:  if (size_ok) cmd_q <= cmd_dec;
                            IDX_DATA: data_q <= host_wdata[HOST_DW-1 -: INT_DW];
                            default:  ;
                        endcase
                    end else begin
                        unique case (idx)
                            IDX_STAT: begin
                                rdata_q  <= status_q;
                                status_q <= '0;
                            end
                            IDX_DATA: rdata_q <= {data_q, {(HOST_DW-INT_DW){1'b0}}};
                            default:  rdata_q <= '0;
                        endcase
                    end
                end
            end
            if (done_evt) status_q <= status_new;
        end
    end

    assign host_rdata = rdata_q;
    assign int_we     = !cmd_q.rd;
    assign int_addr   = cmd_q.addr;
    assign int_size   = cmd_q.size;
endmodule

// File: rtl/ind_cmd_bridge_chk.sv
module ind_cmd_bridge_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_we,
    input logic [4:0]  host_addr,
    input logic [7:0]  host_be,
    input logic        host_ack,
    input logic [63:0] host_rdata,
    input logic        int_valid,
    input logic        int_ready,
    input logic        int_we,
    input logic [31:0] int_addr,
    input logic [3:0]  int_size
);
    assert_hold_req_R10: assert property (@(posedge clk) disable iff (rst)
        int_valid && !int_ready |=> int_valid && $stable(int_addr) && $stable(int_we) && $stable(int_size));

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    assert_size_limit_R3: assert property (@(posedge clk) disable iff (rst)
        int_valid |-> (int_size <= 4'd8));

    assert_ctrl_zero_R9: assert property (@(posedge clk) disable iff (rst)
        host_ack && !host_we && (&host_be) && (host_addr[2:0] == 3'b0) && !host_addr[4]
        |-> host_rdata == 64'h0);

    assert_data_low_R8: assert property (@(posedge clk) disable iff (rst)
        host_ack && !host_we && (host_addr[4:3] == 2'd3) |-> host_rdata[31:0] == 32'h0);

    assert_partial_zero_R1: assert property (@(posedge clk) disable iff (rst)
        host_ack && !host_we && !(&host_be) |-> host_rdata == 64'h0);
endmodule

bind ind_cmd_bridge ind_cmd_bridge_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_be    (host_be),
    .host_ack   (host_ack),
    .host_rdata (host_rdata),
    .int_valid  (int_valid),
    .int_ready  (int_ready),
    .int_we     (int_we),
    .int_addr   (int_addr),
    .int_size   (int_size)
);

// File: tb/ind_cmd_bridge_tb_top.sv
module ind_cmd_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [7:0]  host_be = '0;
    logic [63:0] host_wdata = '0;
    logic        host_ack;
    logic [63:0] host_rdata;
    logic        int_valid, int_we;
    logic        int_ready = 1'b0;
    logic [31:0] int_addr, int_wdata;
    logic [3:0]  int_size;
    logic        int_rvalid = 1'b0, int_err = 1'b0;
    logic [31:0] int_rdata = '0;

    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    ind_cmd_bridge dut_i (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata), .int_valid(int_valid),
        .int_ready(int_ready), .int_we(int_we), .int_addr(int_addr),
        .int_size(int_size), .int_wdata(int_wdata), .int_rvalid(int_rvalid),
        .int_rdata(int_rdata), .int_err(int_err)
    );

    // internal bus model
    function automatic logic [31:0] lane_model(input logic [31:0] a);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = a[7:0] + 8'(8'h11 * (k + 1));
        return r;
    endfunction

    logic        pend = 1'b0;
    logic [1:0]  rcnt = '0;
    logic [31:0] paddr = '0;
    int          txn_cnt = 0;
    logic [31:0] cap_addr = '0, cap_wdata = '0;
    logic [3:0]  cap_size = '0;
    logic        cap_we = 1'b0;

    always @(posedge clk) begin
        int_rvalid <= 1'b0;
        int_ready  <= int_valid && !int_ready;
        if (int_valid && int_ready) begin
            pend      <= 1'b1;
            rcnt      <= 2'd2;
            paddr     <= int_addr;
            txn_cnt   <= txn_cnt + 1;
            cap_addr  <= int_addr;
            cap_size  <= int_size;
            cap_we    <= int_we;
            cap_wdata <= int_wdata;
        end else if (pend) begin
            if (rcnt == 0) begin
                int_rvalid <= 1'b1;
                int_rdata  <= lane_model(paddr);
                int_err    <= (paddr[31:28] == 4'hF);
                pend       <= 1'b0;
            end else begin
                rcnt <= rcnt - 1'b1;
            end
        end
    end

    // scoreboard
    logic [63:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (host_ack && !host_we) begin
                if (exp_q.size() == 0) check("scoreboard-empty", 64'h1, 64'h0);
                else check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic access(input logic we, input logic [4:0] a, input logic [63:0] wd,
                          input logic [7:0] be);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd; host_be = be;
        do @(negedge clk); while (!host_ack);
        host_req = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] be, input logic [63:0] exp,
                      input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, a, 64'h0, be);
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] wd, input logic [7:0] be);
        access(1'b1, a, wd, be);
    endtask

    function automatic logic [63:0] cmdw(input logic r, input logic [3:0] sz, input logic [31:0] a);
        return (64'(r) << 48) | (64'(sz) << 56) | 64'(a);
    endfunction

    function automatic logic [63:0] exp_read(input logic [31:0] a, input int sz);
        logic [31:0] l, v;
        l = lane_model(a);
        v = '0;
        for (int k = 0; k < 4; k++) if (k < sz) v[8*(3-k) +: 8] = l[8*k +: 8];
        return 64'h800 | (64'(v) << 26);
    endfunction

    localparam logic [4:0] A_CMD = 5'h00, A_RST = 5'h08, A_STAT = 5'h10, A_DATA = 5'h18;

    initial begin
        int t0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        rd(A_STAT, 8'hFF, 64'h0, "R7 reset status");
        rd(A_DATA, 8'hFF, 64'h0, "R8 reset data");

        wr(A_DATA, 64'hDEADBEEF_12345678, 8'hFF);
        rd(A_DATA, 8'hFF, 64'hDEADBEEF_00000000, "R8 data readback");
        wr(A_DATA, 64'h11111111_00000000, 8'h0F);
        rd(A_DATA, 8'hFF, 64'hDEADBEEF_00000000, "R1 partial write ignored");
        rd(A_DATA, 8'hF0, 64'h0, "R1 partial read zero");
        wr(A_DATA | 5'h4, 64'h22222222_00000000, 8'hFF);
        rd(A_DATA, 8'hFF, 64'hDEADBEEF_00000000, "R1 misaligned write ignored");

        rd(A_CMD, 8'hFF, 64'h0, "R9 command reads zero");
        rd(A_RST, 8'hFF, 64'h0, "R9 reset reads zero");
        wr(A_STAT, 64'hFFFFFFFF_FFFFFFFF, 8'hFF);
        wr(A_RST, 64'hFFFFFFFF_FFFFFFFF, 8'hFF);
        rd(A_STAT, 8'hFF, 64'h0, "R9 status write ignored");
        check("R9 no transaction", 64'(txn_cnt), 64'd0);

        // full read
        t0 = txn_cnt;
        wr(A_CMD, cmdw(1'b1, 4'd4, 32'h0000_0100), 8'hFF);
        check("R10 ack after response", 64'(txn_cnt), 64'(t0 + 1));
        check("R2 address field", 64'(cap_addr), 64'h100);
        check("R2 size field", 64'(cap_size), 64'd4);
        check("R2 read direction", 64'(cap_we), 64'd0);
        rd(A_STAT, 8'hFF, exp_read(32'h100, 4), "R4 read status");
        rd(A_STAT, 8'hFF, 64'h0, "R7 cleared after read");

        // short read, masked lanes
        wr(A_CMD, cmdw(1'b1, 4'd2, 32'h0000_0240), 8'hFF);
        rd(A_STAT, 8'hFF, exp_read(32'h240, 2), "R4 two-byte read");
        wr(A_CMD, cmdw(1'b1, 4'd1, 32'h0000_0003), 8'hFF);
        rd(A_STAT, 8'hFF, exp_read(32'h3, 1), "R4 one-byte read");

        // failed read
        wr(A_CMD, cmdw(1'b1, 4'd4, 32'hF000_0000), 8'hFF);
        rd(A_STAT, 8'hFF, 64'h800 | (64'hFFFFFFFF << 26), "R5 failed read");

        // write
        wr(A_DATA, 64'hA1B2C3D4_00000000, 8'hFF);
        wr(A_CMD, cmdw(1'b0, 4'd4, 32'h0000_0300), 8'hFF);
        check("R6 byte order", 64'(cap_wdata), 64'hD4C3B2A1);
        check("R2 write direction", 64'(cap_we), 64'd1);
        rd(A_STAT, 8'hFF, 64'h800, "R6 write status");
        wr(A_CMD, cmdw(1'b0, 4'd4, 32'hF000_0010), 8'hFF);
        rd(A_STAT, 8'hFF, 64'h800, "R6 failed write status");

        // rejected size
        wr(A_CMD, cmdw(1'b1, 4'd4, 32'h0000_0180), 8'hFF);
        t0 = txn_cnt;
        wr(A_CMD, cmdw(1'b1, 4'd9, 32'h0000_0500), 8'hFF);
        repeat (6) @(negedge clk);
        check("R3 no transaction", 64'(txn_cnt), 64'(t0));
        rd(A_STAT, 8'hFF, exp_read(32'h180, 4), "R3 status unchanged");
        wr(A_CMD, cmdw(1'b1, 4'd8, 32'h0000_0040), 8'hFF);
        rd(A_STAT, 8'hFF, exp_read(32'h40, 8), "R3 size 8 accepted");

        repeat (4) @(negedge clk);
        check("scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule